// File: doc/BRIEF.md
# Vectored Interrupt Controller with Return Tracking

This block is the interrupt front end of a small 8-bit controller core. Six request sources feed it: two external pins, timers 0 and 1, a serial port with receive and transmit events, and timer 2 with overflow and external-capture events. Each external pin can detect either a low level or a high-to-low transition. The block keeps one request flag per event. At each instruction boundary it picks the highest-ranked source that is pending and enabled, and gives the core an acknowledge together with that source's fixed vector address.

Flags are cleared in hardware on acknowledge only where the source allows it. Once an interrupt is taken, the block marks a service routine as in progress and blocks any further acknowledge. Only a return that the core flags as an interrupt return ends that state, so an ordinary subroutine return leaves interrupts blocked. Software can set or clear any flag through a masked write port. A configuration write sets the per-source enables, the global enable and the trigger mode of each pin.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset all flags read 0, no routine is in service, every enable is 0 and both pins are in level mode (cfgEdge bits 0). With a boundary strobe, ack stays 0 and vector reads 0x0000.
- R2: Level mode sets the pin's flag in the cycle after the pin is sampled low. For pin 0 this is flag bit 0 and for pin 1 it is flag bit 2. The flag follows the pin and is not cleared by acknowledge while the pin stays low.
- R3: In edge mode (cfgEdge bit set), the pin's flag is set only when one sample is high and the next is low. Holding the pin low does not set it again. Acknowledging that source clears the flag.
- R4: A pulse on tmrOvf[0] sets flag bit 1 and a pulse on tmrOvf[1] sets flag bit 3. Acknowledging timer 0 or timer 1 clears that bit.
- R5: Serial receive and transmit set flag bits 4 and 5. Timer 2 overflow and external events set flag bits 6 and 7. These bits are never cleared by acknowledge. The serial request is bit 4 OR bit 5, and the timer 2 request is bit 6 OR bit 7.
- R6: ack is asserted, in the same cycle as the boundary strobe, only when the global enable is set, no routine is in service and some enabled source (cfgSrcEn bit = source rank) is pending. vector is 0x0003 + 8*rank while ack is high and 0x0000 otherwise.
- R7: When several enabled sources are pending, the lowest rank wins. The ranks are: pin 0 = 0, timer 0 = 1, pin 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5.
- R8: inService rises in the cycle after ack and blocks all further acknowledges. Only retDone with retFromIrq high clears it. retDone with retFromIrq low has no effect.
- R9: A masked software write loads swData into the flags selected by swMask. A hardware set of the same flag in the same cycle takes precedence over a software clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 2 | External request pins 0 and 1 |
| tmrOvf | input | 2 | Overflow pulses of timers 0 and 1 |
| serEvt | input | 2 | Serial receive (bit 0) and transmit (bit 1) pulses |
| t2Evt | input | 2 | Timer 2 overflow (bit 0) and external (bit 1) pulses |
| swWe | input | 1 | Software flag write strobe |
| swMask | input | 8 | Flags affected by the software write |
| swData | input | 8 | Values written to the selected flags |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSrcEn | input | 6 | Per-source enables, indexed by rank |
| cfgGlobEn | input | 1 | Global enable |
| cfgEdge | input | 2 | Trigger mode per pin, 1 = edge |
| boundary | input | 1 | Instruction boundary strobe |
| retDone | input | 1 | A return instruction completed |
| retFromIrq | input | 1 | Qualifies retDone as an interrupt return |
| ack | output | 1 | Interrupt accepted this cycle |
| vector | output | 16 | Service routine address, 0 when idle |
| flags | output | 8 | Current request flags |
| inService | output | 1 | A service routine is in progress |

## Verification
On every cycle, the assertions check the following. Acknowledge appears only on a boundary and never while in service. The vector is zero when idle and sits on the 8-byte grid otherwise. Entry into service follows ack, and only the interrupt-return pulse ends it. The serial flags survive acknowledge, the timer 0 flag is cleared by it, and a timer set beats any write. Which source wins under a given pattern of pending flags and enables, and how the pin detectors react to levels and transitions, can only be shown by the bench's sweep over all 4096 combinations of pending sources and enable masks and by its directed pin sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 6;
  localparam int NFLAG = 8;
  localparam int NPIN  = 2;

  typedef struct packed {
    logic            take;
    logic [NSRC-1:0] grant;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_dp.sv
module irq_dp
  import irq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPIN-1:0]  extPin,
  input  logic [1:0]       tmrOvf,
  input  logic [1:0]       serEvt,
  input  logic [1:0]       t2Evt,
  input  logic             swWe,
  input  logic [NFLAG-1:0] swMask,
  input  logic [NFLAG-1:0] swData,
  input  logic             cfgWe,
  input  logic [NSRC-1:0]  cfgSrcEn,
  input  logic             cfgGlobEn,
  input  logic [NPIN-1:0]  cfgEdge,
  input  ctlStrobe_t       strobe,
  output logic [NSRC-1:0]  req,
  output logic [NFLAG-1:0] flags,
  output logic [VEC_W-1:0] vector
);
  logic [NFLAG-1:0] flagReg, flagNext, hwSet, ackClr;
  logic [NPIN-1:0]  prevPin, edgeMode, fallSeen;
  logic [NSRC-1:0]  srcEn, pending;
  logic             globEn;

  assign fallSeen = prevPin & ~extPin;

  always_comb begin
    hwSet    = {t2Evt[1], t2Evt[0], serEvt[1], serEvt[0],
                tmrOvf[1], fallSeen[1] & edgeMode[1],
                tmrOvf[0], fallSeen[0] & edgeMode[0]};
    ackClr   = '0;
    ackClr[0] = strobe.take & strobe.grant[0] & edgeMode[0];
    ackClr[1] = strobe.take & strobe.grant[1];
    ackClr[2] = strobe.take & strobe.grant[2] & edgeMode[1];
    ackClr[3] = strobe.take & strobe.grant[3];
    flagNext = flagReg;
    if (swWe) flagNext = (flagNext & ~swMask) | (swData & swMask);
    flagNext = (flagNext & ~ackClr) | hwSet;
    if (!edgeMode[0]) flagNext[0] = ~extPin[0];
    if (!edgeMode[1]) flagNext[2] = ~extPin[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg  <= '0;
      prevPin  <= '0;
      edgeMode <= '0;
      srcEn    <= '0;
      globEn   <= 1'b0;
    end else begin
      flagReg <= flagNext;
      prevPin <= extPin;
      if (cfgWe) begin
        edgeMode <= cfgEdge;
        srcEn    <= cfgSrcEn;
        globEn   <= cfgGlobEn;
      end
    end
  end

  assign pending = {flagReg[7] | flagReg[6], flagReg[5] | flagReg[4],
                    flagReg[3], flagReg[2], flagReg[1], flagReg[0]};
  assign req     = pending & srcEn & {NSRC{globEn}};
  assign flags   = flagReg;

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++)
      if (strobe.take && strobe.grant[i])
        vector = VEC_W'(VEC_BASE + VEC_STRIDE * i);
  end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] req,
  input  logic            boundary,
  input  logic            retDone,
  input  logic            retFromIrq,
  output ctlStrobe_t      strobe,
  output logic            inService
);
  logic busy;

  always_comb begin
    strobe.grant = req & (~req + NSRC'(1));
    strobe.take  = boundary & ~busy & (|req);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  busy <= 1'b0;
    else if (strobe.take)       busy <= 1'b1;
    else if (retDone && retFromIrq) busy <= 1'b0;
  end

  assign inService = busy;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       extPin,
  input  logic [1:0]       tmrOvf,
  input  logic [1:0]       serEvt,
  input  logic [1:0]       t2Evt,
  input  logic             swWe,
  input  logic [7:0]       swMask,
  input  logic [7:0]       swData,
  input  logic             cfgWe,
  input  logic [5:0]       cfgSrcEn,
  input  logic             cfgGlobEn,
  input  logic [1:0]       cfgEdge,
  input  logic             boundary,
  input  logic             retDone,
  input  logic             retFromIrq,
  output logic             ack,
  output logic [VEC_W-1:0] vector,
  output logic [7:0]       flags,
  output logic             inService
);
  ctlStrobe_t      strobe;
  logic [NSRC-1:0] req;

  irq_dp #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) uDp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .tmrOvf(tmrOvf),
    .serEvt(serEvt), .t2Evt(t2Evt), .swWe(swWe), .swMask(swMask),
    .swData(swData), .cfgWe(cfgWe), .cfgSrcEn(cfgSrcEn),
    .cfgGlobEn(cfgGlobEn), .cfgEdge(cfgEdge), .strobe(strobe),
    .req(req), .flags(flags), .vector(vector)
  );

  irq_ctl uCtl (
    .clk(clk), .rstN(rstN), .req(req), .boundary(boundary),
    .retDone(retDone), .retFromIrq(retFromIrq), .strobe(strobe),
    .inService(inService)
  );

  assign ack = strobe.take;
endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       tmrOvf,
  input logic             swWe,
  input logic             boundary,
  input logic             retDone,
  input logic             retFromIrq,
  input logic             ack,
  input logic [VEC_W-1:0] vector,
  input logic [7:0]       flags,
  input logic             inService
);
  localparam logic [VEC_W-1:0] T0_VEC  = VEC_W'(VEC_BASE + VEC_STRIDE);
  localparam logic [VEC_W-1:0] SER_VEC = VEC_W'(VEC_BASE + 4 * VEC_STRIDE);

  AST_ACK_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> boundary);  // R6
  AST_IDLE_VECTOR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ack |-> vector == '0);  // R6
  AST_VECTOR_ON_GRID: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> (vector >= VEC_W'(VEC_BASE)) && ((vector - VEC_W'(VEC_BASE)) % VEC_W'(VEC_STRIDE) == '0));  // R6
  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> inService);  // R8
  AST_SERVICE_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    inService |-> !ack);  // R8
  AST_PLAIN_RET_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    inService && !(retDone && retFromIrq) |=> inService);  // R8
  AST_IRQ_RET_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    retDone && retFromIrq && !ack |=> !inService);  // R8
  AST_SERIAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ack && vector == SER_VEC && !swWe |=> flags[5:4] != 2'b00);  // R5
  AST_TMR0_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ack && vector == T0_VEC && !swWe && !tmrOvf[0] |=> !flags[1]);  // R4
  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf[0] |=> flags[1]);  // R9
endmodule

bind vec_irq_ctrl irq_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) uChk (
  .clk(clk), .rstN(rstN), .tmrOvf(tmrOvf), .swWe(swWe), .boundary(boundary),
  .retDone(retDone), .retFromIrq(retFromIrq), .ack(ack), .vector(vector),
  .flags(flags), .inService(inService)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/100ps
module vec_irq_ctrl_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] extPin = 2'b11, tmrOvf = '0, serEvt = '0, t2Evt = '0, cfgEdge = '0;
  logic swWe = 1'b0, cfgWe = 1'b0, cfgGlobEn = 1'b0, boundary = 1'b0;
  logic retDone = 1'b0, retFromIrq = 1'b0;
  logic [7:0] swMask = '0, swData = '0;
  logic [5:0] cfgSrcEn = '0;
  logic ack, inService;
  logic [15:0] vector;
  logic [7:0] flags;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setCfg(input logic [5:0] en, input logic glob, input logic [1:0] edg);
    cfgWe = 1'b1; cfgSrcEn = en; cfgGlobEn = glob; cfgEdge = edg;
    tick(); cfgWe = 1'b0;
  endtask

  task automatic irqReturn();
    retDone = 1'b1; retFromIrq = 1'b1; tick(); retDone = 1'b0; retFromIrq = 1'b0;
  endtask

  // boundary strobe: check combinational ack/vector, then let the edge apply
  task automatic tryAck(input bit expAck, input int expVec, input string tag);
    boundary = 1'b1; #1;
    chk(ack == expAck, tag, ack, expAck);
    chk(vector == 16'(expVec), tag, vector, expVec);
    tick(); boundary = 1'b0;
  endtask

  function automatic int expVector(input logic [5:0] live);
    for (int i = 0; i < 6; i++) if (live[i]) return 3 + 8 * i;
    return 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick(); rstN = 1'b1; tick();
    // R1 reset state
    chk(flags == 8'h00, "R1 flags", flags, 0);
    chk(inService == 1'b0, "R1 inService", inService, 0);
    setCfg(6'h00, 1'b1, 2'b00);
    tryAck(1'b0, 0, "R1 no ack with enables clear");
    // R2 level mode (default after reset) on pin 0
    setCfg(6'h01, 1'b1, 2'b00);
    extPin[0] = 1'b0; tick();
    chk(flags[0] == 1'b1, "R2 low sets flag0", flags[0], 1);
    tryAck(1'b1, 'h03, "R2 ack pin0");
    chk(flags[0] == 1'b1, "R2 level flag kept on ack", flags[0], 1);
    irqReturn();
    extPin[0] = 1'b1; tick();
    chk(flags[0] == 1'b0, "R2 flag follows pin high", flags[0], 0);
    // R2 level on pin 1 -> flag bit 2
    extPin[1] = 1'b0; tick();
    chk(flags[2] == 1'b1, "R2 pin1 sets flag2", flags[2], 1);
    extPin[1] = 1'b1; tick();
    // R3 edge mode on pin 0
    setCfg(6'h01, 1'b1, 2'b01);
    extPin[0] = 1'b0; tick();
    chk(flags[0] == 1'b1, "R3 fall sets flag0", flags[0], 1);
    swWe = 1'b1; swMask = 8'h01; swData = 8'h00; tick(); swWe = 1'b0;
    tick(); tick();
    chk(flags[0] == 1'b0, "R3 held low does not re-set", flags[0], 0);
    extPin[0] = 1'b1; tick(); extPin[0] = 1'b0; tick();
    tryAck(1'b1, 'h03, "R3 ack edge pin0");
    chk(flags[0] == 1'b0, "R3 ack clears edge flag", flags[0], 1'b0);
    irqReturn(); extPin[0] = 1'b1;
    setCfg(6'h00, 1'b1, 2'b00);
    // R4 timer 1 pulse, ack clears
    tmrOvf[1] = 1'b1; tick(); tmrOvf[1] = 1'b0;
    chk(flags[3] == 1'b1, "R4 timer1 sets flag3", flags[3], 1);
    setCfg(6'h08, 1'b1, 2'b00);
    tryAck(1'b1, 'h1B, "R4 ack timer1");
    chk(flags[3] == 1'b0, "R4 ack clears flag3", flags[3], 0);
    irqReturn();
    // R5 serial transmit and timer 2 external stay set
    serEvt[1] = 1'b1; tick(); serEvt[1] = 1'b0;
    chk(flags[5] == 1'b1, "R5 tx sets flag5", flags[5], 1);
    setCfg(6'h10, 1'b1, 2'b00);
    tryAck(1'b1, 'h23, "R5 ack serial via tx");
    chk(flags[5] == 1'b1, "R5 serial flag not cleared", flags[5], 1);
    irqReturn();
    t2Evt[1] = 1'b1; tick(); t2Evt[1] = 1'b0;
    setCfg(6'h20, 1'b1, 2'b00);
    tryAck(1'b1, 'h2B, "R5 ack timer2 via ext");
    chk(flags[7] == 1'b1, "R5 timer2 flag not cleared", flags[7], 1);
    // R8 service blocking and return handling
    chk(inService == 1'b1, "R8 in service after ack", inService, 1);
    tryAck(1'b0, 0, "R8 blocked while in service");
    retDone = 1'b1; retFromIrq = 1'b0; tick(); retDone = 1'b0;
    chk(inService == 1'b1, "R8 plain return ignored", inService, 1);
    tryAck(1'b0, 0, "R8 still blocked after plain return");
    irqReturn();
    chk(inService == 1'b0, "R8 interrupt return ends service", inService, 0);
    tryAck(1'b1, 'h2B, "R8 ack again after interrupt return");
    irqReturn();
    // R9 software write and hardware priority
    swWe = 1'b1; swMask = 8'hF0; swData = 8'h00; tick();
    chk(flags == 8'h00, "R9 masked clear", flags, 0);
    swMask = 8'h40; swData = 8'hFF; tick();
    chk(flags == 8'h40, "R9 masked set only bit6", flags, 'h40);
    swMask = 8'h02; swData = 8'h00; tmrOvf[0] = 1'b1; tick();
    swWe = 1'b0; tmrOvf[0] = 1'b0;
    chk(flags[1] == 1'b1, "R9 hw set beats sw clear", flags[1], 1);
    // R6 global enable gates everything
    setCfg(6'h3F, 1'b0, 2'b00);
    tryAck(1'b0, 0, "R6 global enable off");
    // R6/R7 sweep: every pending pattern against every enable mask
    for (int p = 0; p < 64; p++) begin
      for (int e = 0; e < 64; e++) begin
        logic [5:0] pv, ev;
        pv = 6'(p); ev = 6'(e);
        cfgWe = 1'b1; cfgSrcEn = ev; cfgGlobEn = 1'b1; cfgEdge = 2'b00;
        swWe = 1'b1; swMask = 8'hFF;
        swData = {1'b0, pv[5], 1'b0, pv[4], pv[3], 1'b0, pv[1], 1'b0};
        extPin = {~pv[2], ~pv[0]};
        tick(); cfgWe = 1'b0; swWe = 1'b0;
        tryAck((pv & ev) != 0, expVector(pv & ev), "R7 priority sweep");
        if ((pv & ev) != 0) irqReturn();
      end
    end
    extPin = 2'b11;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule